// File: doc/BRIEF.md
# Stall-Based Page Fault Controller

This controller arbitrates every memory access issued by an executing processor against a small cache. Lookup logic outside the block reports three flags for the presented address: hit, legal and resident. The controller turns them into one of four responses. A hit completes at once. A miss on a resident page stalls the requester with wait states while the cache refills. An illegal address ends in a bus error. A legal access to a page that is not resident is handed to a second, fault-service processor.

Two policies cover the non-resident case. In stall mode, a hold flop is set. It keeps the requester in wait states for as many cycles as needed, until the service processor pulses a release. The controller then evaluates the same access again. In restartable mode, the requester receives an immediate page-fault response and no hold flop is used. In both modes, the service processor gets a request line together with the latched faulting address and direction. Only one fault is outstanding at a time.

Top module: `page_fault_ctrl`

## Requirements
- R1: A valid, legal access that hits, with no hold active, asserts req_ready_o in the same cycle and never req_wait_o.
- R2: A valid, legal, resident access that misses asserts req_wait_o and fill_req_o in every cycle it is presented, with no cycle limit, and completes in the first cycle the hit flag rises.
- R3: A valid access with legal low asserts req_err_o in the same cycle, without wait states, whatever the hit and resident flags show, and never raises svc_req_o.
- R4: In stall mode (mode_restart_i = 0), a valid, legal, non-resident miss with no fault outstanding asserts req_wait_o, sets the hold flop, and in the next cycle drives svc_req_o high with svc_addr_o and svc_we_o equal to that access's address and direction.
- R5: While the hold flop is set, req_wait_o stays high for a valid request whatever the lookup flags show. Only a svc_release_i pulse clears the flop, and the access is evaluated normally from the following cycle.
- R6: In restartable mode (mode_restart_i = 1), a valid, legal, non-resident miss with no fault outstanding asserts req_pf_o in the same cycle, never sets the hold flop, and drives svc_req_o high in the next cycle.
- R7: svc_req_o stays high until a cycle with svc_ack_i high, and svc_addr_o holds its value meanwhile. A further non-resident miss seen while svc_req_o is high gets req_wait_o and does not replace the latched address.
- R8: A svc_release_i pulse while the hold flop is clear changes no output and no pending request.
- R9: If the page is still not resident when the access is evaluated again after a release, a new service request is raised for it rather than completing the access.
- R10: rst_ni low clears the hold flop and svc_req_o asynchronously.
- R11: With req_valid_i low, none of req_ready_o, req_wait_o, req_err_o, req_pf_o and fill_req_o is asserted. With it high, exactly one of the first four is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_restart_i | input | 1 | 1 = restartable page faults, 0 = stall until fixed |
| req_valid_i | input | 1 | Executor access valid |
| req_addr_i | input | ADDR_W | Executor access address |
| req_we_i | input | 1 | Executor access is a write |
| req_ready_o | output | 1 | Access completes this cycle |
| req_wait_o | output | 1 | Wait state this cycle |
| req_err_o | output | 1 | Bus error, access terminated |
| req_pf_o | output | 1 | Restartable page fault, access terminated |
| lk_hit_i | input | 1 | Cache holds the presented address |
| lk_legal_i | input | 1 | Address is legal for the requester |
| lk_resident_i | input | 1 | Page of the address is in memory |
| fill_req_o | output | 1 | Ask the cache to refill the presented line |
| svc_req_o | output | 1 | Fault pending for the service processor |
| svc_addr_o | output | ADDR_W | Latched faulting address |
| svc_we_o | output | 1 | Latched faulting direction |
| svc_ack_i | input | 1 | Service processor takes the pending request |
| svc_release_i | input | 1 | Service processor frees a stalled requester |

## Verification
A hold flop left set by mistake shows as req_wait_o on the very next valid cycle, even when the lookup reports a hit. A flop that was never set shows as a premature ready or a second fault on the cycle after the fault. A service latch that drops early or loads a second address shows at svc_req_o or svc_addr_o one clock after the offending edge. The bench keeps its own model of the hold flop and the pending request, and compares every response output in every cycle, so each of these faults is reported within one cycle of the edge that caused it.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [2:0] {
    RSP_IDLE,
    RSP_DONE,
    RSP_WAIT,
    RSP_ERR,
    RSP_PF
  } rsp_e;
endpackage

// File: rtl/pfc_classify.sv
module pfc_classify
  import pfc_pkg::*;
(
  input  logic valid_i,
  input  logic hold_i,
  input  logic pending_i,
  input  logic restart_i,
  input  logic legal_i,
  input  logic hit_i,
  input  logic resident_i,
  output rsp_e rsp_o,
  output logic fill_o,
  output logic fault_o
);
  // legality first, then hit, then residency
  always_comb begin
    rsp_o   = RSP_IDLE;
    fill_o  = 1'b0;
    fault_o = 1'b0;
    if (valid_i) begin
      if (hold_i) begin
        rsp_o = RSP_WAIT;
      end else if (!legal_i) begin
        rsp_o = RSP_ERR;
      end else if (hit_i) begin
        rsp_o = RSP_DONE;
      end else if (resident_i) begin
        rsp_o  = RSP_WAIT;
        fill_o = 1'b1;
      end else if (pending_i) begin
        rsp_o = RSP_WAIT;
      end else begin
        fault_o = 1'b1;
        rsp_o   = restart_i ? RSP_PF : RSP_WAIT;
      end
    end
  end
endmodule

// File: rtl/pfc_hold_flop.sv
module pfc_hold_flop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic release_i,
  output logic hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_o <= 1'b0;
    else if (set_i)              hold_o <= 1'b1;
    else if (release_i && hold_o) hold_o <= 1'b0;
  end
endmodule

// File: rtl/pfc_svc_latch.sv
module pfc_svc_latch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        req_o <= 1'b0;
    else if (capture_i) req_o <= 1'b1;
    else if (ack_i)     req_o <= 1'b0;
  end

  // address loads only on capture, so it is stable while req_o is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      we_o   <= 1'b0;
    end else if (capture_i) begin
      addr_o <= addr_i;
      we_o   <= we_i;
    end
  end
endmodule

// File: rtl/page_fault_ctrl.sv
module page_fault_ctrl
  import pfc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_restart_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  output logic              req_ready_o,
  output logic              req_wait_o,
  output logic              req_err_o,
  output logic              req_pf_o,
  input  logic              lk_hit_i,
  input  logic              lk_legal_i,
  input  logic              lk_resident_i,
  output logic              fill_req_o,
  output logic              svc_req_o,
  output logic [ADDR_W-1:0] svc_addr_o,
  output logic              svc_we_o,
  input  logic              svc_ack_i,
  input  logic              svc_release_i
);
  rsp_e rsp;
  logic hold_q;
  logic fault_evt;

  pfc_classify u_classify (
    .valid_i    (req_valid_i),
    .hold_i     (hold_q),
    .pending_i  (svc_req_o),
    .restart_i  (mode_restart_i),
    .legal_i    (lk_legal_i),
    .hit_i      (lk_hit_i),
    .resident_i (lk_resident_i),
    .rsp_o      (rsp),
    .fill_o     (fill_req_o),
    .fault_o    (fault_evt)
  );

  pfc_hold_flop u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (fault_evt && !mode_restart_i),
    .release_i (svc_release_i),
    .hold_o    (hold_q)
  );

  pfc_svc_latch #(.ADDR_W(ADDR_W)) u_svc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (fault_evt),
    .addr_i    (req_addr_i),
    .we_i      (req_we_i),
    .ack_i     (svc_ack_i),
    .req_o     (svc_req_o),
    .addr_o    (svc_addr_o),
    .we_o      (svc_we_o)
  );

  assign req_ready_o = (rsp == RSP_DONE);
  assign req_wait_o  = (rsp == RSP_WAIT);
  assign req_err_o   = (rsp == RSP_ERR);
  assign req_pf_o    = (rsp == RSP_PF);
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_restart_i,
  input logic              req_valid_i,
  input logic              lk_legal_i,
  input logic              lk_hit_i,
  input logic              req_ready_o,
  input logic              req_wait_o,
  input logic              req_err_o,
  input logic              req_pf_o,
  input logic              fill_req_o,
  input logic              svc_req_o,
  input logic [ADDR_W-1:0] svc_addr_o,
  input logic              svc_ack_i,
  input logic              hold_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(req_ready_o || req_wait_o || req_err_o || req_pf_o || fill_req_o)); // R11
  AST_ONE_RESPONSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $countones({req_ready_o, req_wait_o, req_err_o, req_pf_o}) == 1); // R11
  AST_HIT_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && lk_legal_i && lk_hit_i && !hold_i |-> req_ready_o); // R1
  AST_ILLEGAL_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !lk_legal_i && !hold_i |-> req_err_o && !req_wait_o); // R3
  AST_ILLEGAL_NO_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !lk_legal_i && !svc_req_o |=> !svc_req_o); // R3
  AST_HOLD_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && req_valid_i |-> req_wait_o); // R5
  AST_RESTART_NO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_restart_i && !hold_i |=> !hold_i); // R6
  AST_PF_RAISES_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_pf_o |=> svc_req_o); // R6
  AST_SVC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_req_o && !svc_ack_i |=> svc_req_o && $stable(svc_addr_o)); // R7
endmodule

bind page_fault_ctrl pfc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_restart_i (mode_restart_i),
  .req_valid_i    (req_valid_i),
  .lk_legal_i     (lk_legal_i),
  .lk_hit_i       (lk_hit_i),
  .req_ready_o    (req_ready_o),
  .req_wait_o     (req_wait_o),
  .req_err_o      (req_err_o),
  .req_pf_o       (req_pf_o),
  .fill_req_o     (fill_req_o),
  .svc_req_o      (svc_req_o),
  .svc_addr_o     (svc_addr_o),
  .svc_ack_i      (svc_ack_i),
  .hold_i         (hold_q)
);

// File: tb/page_fault_ctrl_tb.sv
module page_fault_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode = 1'b0;
  logic          valid = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic          legal = 1'b0, hit = 1'b0, res = 1'b0;
  logic          ack = 1'b0, rel = 1'b0;
  logic          ready, wt, err, pf, fill, sreq, swe;
  logic [AW-1:0] saddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  bit          hold_m = 1'b0;
  bit          pend_m = 1'b0;
  logic [AW-1:0] addr_m = '0;
  bit          we_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_fault_ctrl #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_restart_i(mode),
    .req_valid_i(valid), .req_addr_i(addr), .req_we_i(we),
    .req_ready_o(ready), .req_wait_o(wt), .req_err_o(err), .req_pf_o(pf),
    .lk_hit_i(hit), .lk_legal_i(legal), .lk_resident_i(res),
    .fill_req_o(fill), .svc_req_o(sreq), .svc_addr_o(saddr), .svc_we_o(swe),
    .svc_ack_i(ack), .svc_release_i(rel)
  );

  task automatic chk(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected response code: 0 none,1 ready,2 wait,3 err,4 pf ; fill flag in bit 3
  function automatic int exp_rsp(bit v, bit h, bit lg, bit ht, bit rs, bit pd, bit md);
    if (!v) return 0;
    if (h) return 2;
    if (!lg) return 3;
    if (ht) return 1;
    if (rs) return 2 | 8;
    if (pd) return 2;
    return md ? 4 : 2;
  endfunction

  function automatic string rsp_tag(bit v, bit h, bit lg, bit ht, bit rs, bit pd, bit md);
    if (!v) return "R11";
    if (h) return "R5";
    if (!lg) return "R3";
    if (ht) return "R1";
    if (rs) return "R2";
    if (pd) return "R7";
    return md ? "R6" : "R4";
  endfunction

  task automatic compare_now();
    int e;
    string t;
    e = exp_rsp(valid, hold_m, legal, hit, res, pend_m, mode);
    t = rsp_tag(valid, hold_m, legal, hit, res, pend_m, mode);
    chk({31'd0, ready}, {31'd0, (e & 7) == 1}, {t, " ready"});
    chk({31'd0, wt},    {31'd0, (e & 7) == 2}, {t, " wait"});
    chk({31'd0, err},   {31'd0, (e & 7) == 3}, {t, " err"});
    chk({31'd0, pf},    {31'd0, (e & 7) == 4}, {t, " pf"});
    chk({31'd0, fill},  {31'd0, (e & 8) != 0}, {t, " fill"});
    chk({31'd0, sreq},  {31'd0, pend_m}, "R7 svc_req");
    if (pend_m) begin
      chk(saddr, addr_m, "R7 svc_addr");
      chk({31'd0, swe}, {31'd0, we_m}, "R4 svc_we");
    end
  endtask

  task automatic step(input bit v, input logic [AW-1:0] a, input bit w, input bit lg,
                      input bit ht, input bit rs, input bit md, input bit ak, input bit rl);
    bit ev;
    @(negedge clk);
    valid = v; addr = a; we = w; legal = lg; hit = ht; res = rs;
    mode = md; ack = ak; rel = rl;
    #2;
    compare_now();
    @(posedge clk);
    #1;
    ev = v && !hold_m && lg && !ht && !rs && !pend_m;
    if (hold_m && rl) hold_m = 1'b0;
    if (pend_m && ak) pend_m = 1'b0;
    if (ev) begin
      pend_m = 1'b1; addr_m = a; we_m = w; hold_m = !md;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R10 reset state
    #(CLK_PERIOD * 2 + 2);
    chk({31'd0, sreq}, 32'd0, "R10 svc_req in reset");
    chk({31'd0, wt}, 32'd0, "R10 wait in reset");
    @(negedge clk); rst_ni = 1'b1;

    // R1 hit, R3 illegal overriding hit/resident
    step(1, 32'h1000, 0, 1, 1, 1, 0, 0, 0);
    step(1, 32'h2000, 0, 0, 1, 1, 0, 0, 0);
    step(1, 32'h2004, 1, 0, 0, 0, 0, 0, 0);
    chk({31'd0, sreq}, 32'd0, "R3 illegal no service request");
    // R2 refill wait across several cycles, then hit
    for (int i = 0; i < 5; i++) step(1, 32'h3000, 0, 1, 0, 1, 0, 0, 0);
    step(1, 32'h3000, 0, 1, 1, 1, 0, 0, 0);
    // R4/R5 stall: fault, long hold, lookup shows hit but still waits
    step(1, 32'h4440, 1, 1, 0, 0, 0, 0, 0);
    chk({31'd0, sreq}, 32'd1, "R4 service request raised");
    chk(saddr, 32'h4440, "R4 latched address");
    for (int i = 0; i < 4; i++) step(1, 32'h4440, 1, 1, 1, 1, 0, 0, 0);
    step(1, 32'h4440, 1, 1, 1, 1, 0, 1, 0);           // ack, still held
    chk({31'd0, sreq}, 32'd0, "R7 ack drops request");
    // R9 release while page still missing -> new request
    step(1, 32'h4440, 1, 1, 0, 0, 0, 0, 1);
    step(1, 32'h4440, 1, 1, 0, 0, 0, 0, 0);
    chk({31'd0, sreq}, 32'd1, "R9 new request after release");
    step(1, 32'h4440, 1, 1, 0, 0, 0, 1, 1);
    step(1, 32'h4440, 1, 1, 1, 1, 0, 0, 0);
    chk({31'd0, ready}, 32'd1, "R5 retried access completed");
    // R6 restartable fault, R7 second fault waits, R8 stray release
    step(1, 32'h5550, 0, 1, 0, 0, 1, 0, 0);
    step(1, 32'h6660, 0, 1, 0, 0, 1, 0, 0);
    chk(saddr, 32'h5550, "R7 second fault keeps first address");
    step(0, 32'h0, 0, 0, 0, 0, 1, 0, 1);
    chk({31'd0, sreq}, 32'd1, "R8 stray release leaves request");
    step(1, 32'h7000, 0, 1, 1, 0, 1, 0, 1);
    step(1, 32'h0, 0, 1, 1, 1, 1, 1, 0);
    // R10 reset while held
    step(1, 32'h8880, 0, 1, 0, 0, 0, 0, 0);
    @(negedge clk); rst_ni = 1'b0; valid = 1'b0; #2;
    chk({31'd0, sreq}, 32'd0, "R10 reset clears request");
    hold_m = 0; pend_m = 0;
    @(negedge clk); rst_ni = 1'b1;
    step(1, 32'h8880, 0, 1, 1, 1, 0, 0, 0);
    chk({31'd0, ready}, 32'd1, "R10 hold cleared by reset");

    // constrained random
    begin
      bit md = 0;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 60) == 0) md = ~md;
        step(($urandom % 10) < 8, {$urandom % 16, 4'h0}, $urandom % 2,
             ($urandom % 10) < 8, ($urandom % 2) == 1, ($urandom % 2) == 1,
             md, ($urandom % 5) == 0, ($urandom % 4) == 0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule